// File: doc/BRIEF.md
# Platform Health Status Register Bank

This block collects platform health and event signals into a small set of byte-wide status registers that an external management master can read over SMBus. The bank takes the raw inputs: a chassis-open flag, an active thermal event, watchdog expiry pulses, the strobe and data of the processor's first boot fetch, battery-low, power-well signals, a shutdown-message pulse, a processor thermal-trip flag, and a general-purpose alert pin with its polarity control. It also exposes two message bytes and a watchdog status byte, which are supplied by other logic.

Status bits fall into three kinds. Event bits are captured on their first occurrence and held until platform reset. Live bits follow their inputs. One bit is polarity-adjusted. Detection rules cover three cases: a blank-flash check on the first fetch only, a second-expiry tracker for the watchdog, and a power-ramp failure decode.

Reads use a valid/ready request channel that carries a byte index, and a valid/ready response channel that carries a data byte. The response register holds one entry. A new request is accepted only while that entry is empty or is being consumed in the same cycle. While the response is stalled, its data and valid stay fixed. The serial shifter and the host write path are outside this block.

Top module: `plat_status_bank`

## Requirements
- R1: After reset, all captured bits are clear, no response is pending (`rsp_valid_o`=0) and `req_ready_o`=1.
- R2: Index 4 bit 0 (chassis open) and bit 1 (thermal event) set in the clock after their input is high. They stay set until reset.
- R3: Index 4 bit 2 (boot failure) reads 1 from reset until the first fetch strobe (`fetch_vld_i`). After that strobe it reads 0.
- R4: Index 4 bit 3 sets only on a watchdog expiry pulse that arrives while an earlier expiry has already been recorded. A single expiry leaves it 0. It clears only on reset.
- R5: Index 4 bit 7 equals `alert_pin_i` when `alert_inv_i`=1, and equals its inverse when `alert_inv_i`=0. Index 4 bits 6:4 read 0.
- R6: Index 5 bit 0 (blank flash) takes the value (data==0xFF) of the first fetch strobe after reset. Later strobes do not change it.
- R7: Index 5 bits are live. Bit 1 = NOT `batlow_ni`. Bit 2 = `cpu_pwr_fail_i`. Bit 6 = `thermtrip_i`.
- R8: Index 5 bit 3 sets on a shutdown-message pulse and holds until reset. Bit 5 = `slp_s3_ni` AND NOT `pwrok_i`. Bits 4 and 7 read 0.
- R9: Index 6 returns `msg_a_i`, index 7 returns `msg_b_i` and index 8 returns `wdog_stat_i`. Indices 0-3 and 9-255 read 0.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both high at a clock edge. `req_ready_o` = NOT `rsp_valid_o` OR `rsp_ready_i`. The response appears in the following cycle and holds its data while `rsp_ready_i` is low.
- R11: A read of any index has no effect on the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous platform reset, active low |
| intrude_i | input | 1 | Chassis-open flag |
| therm_evt_i | input | 1 | Active thermal event |
| wdt_timeout_i | input | 1 | Watchdog expiry pulse |
| fetch_vld_i | input | 1 | Boot fetch data strobe |
| fetch_data_i | input | 8 | Boot fetch data byte |
| batlow_ni | input | 1 | Battery low, active low |
| cpu_pwr_fail_i | input | 1 | Processor power failure flag |
| shutdown_msg_i | input | 1 | Shutdown message received pulse |
| slp_s3_ni | input | 1 | Sleep-S3 control, active low |
| pwrok_i | input | 1 | Core power good |
| thermtrip_i | input | 1 | Processor thermal-trip status |
| alert_pin_i | input | 1 | Alert / general-purpose pin level |
| alert_inv_i | input | 1 | Alert polarity control |
| msg_a_i | input | 8 | Message byte A |
| msg_b_i | input | 8 | Message byte B |
| wdog_stat_i | input | 8 | Watchdog status byte |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request ready |
| req_idx_i | input | 8 | Read byte index |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_data_o | output | 8 | Response data byte |

## Verification
The bench drives two watchdog expiries and reads index 4 after each one. A design that set the second-expiry bit on the first pulse would show bit 3 high after only one expiry. The bench follows a 0xFF first fetch with a 0x00 fetch, and after a second reset does the reverse. A detector that kept sampling would flip the blank-flash bit, and one that missed the first strobe would leave boot-failure stuck at 1. The bench sweeps all four alert pin and polarity pairs to catch an inverted control. It holds the response channel stalled while changing the message inputs: a bank that overwrote a held response or accepted a second request would return the wrong byte or lose a response.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned SLOT_HLTH = 4;
  localparam int unsigned SLOT_PWR  = 5;
  localparam int unsigned SLOT_MSGA = 6;
  localparam int unsigned SLOT_MSGB = 7;
  localparam int unsigned SLOT_WDOG = 8;
  localparam int unsigned N_SLOTS   = SLOT_WDOG + 1;
  // event capture lanes
  localparam int unsigned EV_INTR   = 0;
  localparam int unsigned EV_THERM  = 1;
  localparam int unsigned EV_SHUT   = 2;
  localparam int unsigned N_EV      = 3;
endpackage

// File: rtl/psb_event_hold.sv
module psb_event_hold #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] held_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
    end
    assign held_o[g] = q;
  end
endmodule

// File: rtl/psb_wdog_track.sv
module psb_wdog_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  output logic first_o,
  output logic second_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o  <= 1'b0;
      second_o <= 1'b0;
    end else if (expire_i) begin
      first_o <= 1'b1;
      if (first_o) second_o <= 1'b1;
    end
  end
endmodule

// File: rtl/psb_fetch_probe.sv
module psb_fetch_probe #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  output logic          seen_o,
  output logic          blank_o
);
  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_o  <= 1'b0;
      blank_o <= 1'b0;
    end else if (vld_i && !seen_o) begin
      seen_o  <= 1'b1;
      blank_o <= (data_i == ERASED);
    end
  end
endmodule

// File: rtl/psb_read_port.sv
module psb_read_port #(
  parameter int unsigned DW     = 8,
  parameter int unsigned IW     = 8,
  parameter int unsigned NSLOTS = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSLOTS-1:0][DW-1:0] slots_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [IW-1:0]            req_idx_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [DW-1:0]            rsp_data_o
);
  logic [DW-1:0] pick;
  logic          take;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (req_idx_i == IW'(i)) pick = slots_i[i];
    end
  end

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign take        = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (take) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= pick;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/plat_status_bank.sv
module plat_status_bank
  import psb_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          intrude_i,
  input  logic          therm_evt_i,
  input  logic          wdt_timeout_i,
  input  logic          fetch_vld_i,
  input  logic [DW-1:0] fetch_data_i,
  input  logic          batlow_ni,
  input  logic          cpu_pwr_fail_i,
  input  logic          shutdown_msg_i,
  input  logic          slp_s3_ni,
  input  logic          pwrok_i,
  input  logic          thermtrip_i,
  input  logic          alert_pin_i,
  input  logic          alert_inv_i,
  input  logic [DW-1:0] msg_a_i,
  input  logic [DW-1:0] msg_b_i,
  input  logic [DW-1:0] wdog_stat_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [IW-1:0] req_idx_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_data_o
);
  logic [N_EV-1:0] ev_set, ev_q;
  logic            wd_first, wd_second;
  logic            fetch_seen, flash_blank;
  logic [DW-1:0]   health, power;
  logic [N_SLOTS-1:0][DW-1:0] slots;

  always_comb begin
    ev_set           = '0;
    ev_set[EV_INTR]  = intrude_i;
    ev_set[EV_THERM] = therm_evt_i;
    ev_set[EV_SHUT]  = shutdown_msg_i;
  end

  psb_event_hold #(.N(N_EV)) u_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(ev_set), .held_o(ev_q)
  );

  psb_wdog_track u_wdog (
    .clk_i (clk_i), .rst_ni(rst_ni), .expire_i(wdt_timeout_i),
    .first_o(wd_first), .second_o(wd_second)
  );

  psb_fetch_probe #(.DW(DW)) u_fetch (
    .clk_i (clk_i), .rst_ni(rst_ni), .vld_i(fetch_vld_i), .data_i(fetch_data_i),
    .seen_o(fetch_seen), .blank_o(flash_blank)
  );

  always_comb begin
    health    = '0;
    health[0] = ev_q[EV_INTR];
    health[1] = ev_q[EV_THERM];
    health[2] = !fetch_seen;
    health[3] = wd_second;
    health[7] = alert_inv_i ? alert_pin_i : !alert_pin_i;

    power     = '0;
    power[0]  = flash_blank;
    power[1]  = !batlow_ni;
    power[2]  = cpu_pwr_fail_i;
    power[3]  = ev_q[EV_SHUT];
    power[5]  = slp_s3_ni && !pwrok_i;
    power[6]  = thermtrip_i;
  end

  always_comb begin
    slots            = '0;
    slots[SLOT_HLTH] = health;
    slots[SLOT_PWR]  = power;
    slots[SLOT_MSGA] = msg_a_i;
    slots[SLOT_MSGB] = msg_b_i;
    slots[SLOT_WDOG] = wdog_stat_i;
  end

  psb_read_port #(.DW(DW), .IW(IW), .NSLOTS(N_SLOTS)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slots_i    (slots),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_idx_i  (req_idx_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i),
    .rsp_data_o (rsp_data_o)
  );
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 8,
  parameter int unsigned NE = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NE-1:0] held_i,
  input logic          wd_first_i,
  input logic          wd_second_i,
  input logic          seen_i,
  input logic          blank_i,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [IW-1:0] req_idx_i,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [DW-1:0] rsp_data_o
);
  logic idx_high_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_high_q <= 1'b0;
    else if (req_valid_i && req_ready_o) idx_high_q <= (req_idx_i > IW'(8));
  end

  // R2, R8: captured events never drop while out of reset
  p_held_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(held_i) & ~held_i) == '0));

  // R4: second expiry only after a first one was already recorded
  p_second_after_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_second_i) |-> $past(wd_first_i));

  // R6: blank-flash result frozen once the first fetch was seen
  p_blank_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_i |=> $stable(blank_i));

  // R10: an accepted request yields a response next cycle
  p_resp_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R10: a stalled response keeps valid and data
  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  // R9: indices above 8 return zero
  p_high_idx_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && idx_high_q) |-> (rsp_data_o == '0));
endmodule

bind plat_status_bank psb_checker #(.DW(DW), .IW(IW), .NE(psb_pkg::N_EV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .held_i     (ev_q),
  .wd_first_i (wd_first),
  .wd_second_i(wd_second),
  .seen_i     (fetch_seen),
  .blank_i    (flash_blank),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_idx_i  (req_idx_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_data_o (rsp_data_o)
);

// File: tb/sim_plat_status_bank.sv
module sim_plat_status_bank;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intrude = 0, therm = 0, wdt = 0, fvld = 0;
  logic [7:0] fdata = 0;
  logic batlow_n = 1, cpufail = 0, shut = 0, slp_n = 0, pwrok = 1, ttrip = 0;
  logic apin = 1, ainv = 0;
  logic [7:0] msga = 8'h3C, msgb = 8'hA5, wdst = 8'h5A;
  logic req_valid = 0, rsp_ready = 1;
  logic [7:0] req_idx = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;

  always #(CLK_P/2) clk = ~clk;

  plat_status_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .intrude_i(intrude), .therm_evt_i(therm),
    .wdt_timeout_i(wdt), .fetch_vld_i(fvld), .fetch_data_i(fdata),
    .batlow_ni(batlow_n), .cpu_pwr_fail_i(cpufail), .shutdown_msg_i(shut),
    .slp_s3_ni(slp_n), .pwrok_i(pwrok), .thermtrip_i(ttrip),
    .alert_pin_i(apin), .alert_inv_i(ainv), .msg_a_i(msga), .msg_b_i(msgb),
    .wdog_stat_i(wdst), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_idx_i(req_idx), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data)
  );

  int checks = 0, errors = 0;

  // bench model of captured state
  logic m_intr = 0, m_therm = 0, m_wd1 = 0, m_wd2 = 0, m_seen = 0, m_blank = 0, m_shut = 0;

  typedef struct { logic [7:0] idx; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_of(input logic [7:0] idx);
    case (idx)
      8'd4: expect_of = {(ainv ? apin : ~apin), 3'b000, m_wd2, ~m_seen, m_therm, m_intr};
      8'd5: expect_of = {1'b0, ttrip, slp_n & ~pwrok, 1'b0, m_shut, cpufail, ~batlow_n, m_blank};
      8'd6: expect_of = msga;
      8'd7: expect_of = msgb;
      8'd8: expect_of = wdst;
      default: expect_of = 8'h00;
    endcase
  endfunction

  task automatic rd(input logic [7:0] idx, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = idx;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    it.idx = idx; it.exp = expect_of(idx); it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_intr();  @(negedge clk); intrude = 1; @(negedge clk); intrude = 0; m_intr = 1; endtask
  task automatic pulse_therm(); @(negedge clk); therm = 1;   @(negedge clk); therm = 0;   m_therm = 1; endtask
  task automatic pulse_shut();  @(negedge clk); shut = 1;    @(negedge clk); shut = 0;    m_shut = 1; endtask
  task automatic pulse_wdt();
    @(negedge clk); wdt = 1; @(negedge clk); wdt = 0;
    if (m_wd1) m_wd2 = 1;
    m_wd1 = 1;
  endtask
  task automatic fetch(input logic [7:0] d);
    @(negedge clk); fvld = 1; fdata = d; @(negedge clk); fvld = 0;
    if (!m_seen) begin m_seen = 1; m_blank = (d == 8'hFF); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    m_intr = 0; m_therm = 0; m_wd1 = 0; m_wd2 = 0; m_seen = 0; m_blank = 0; m_shut = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // monitor: pops on each response handshake
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: actual unexpected response %h expected none", rsp_data);
        end else begin
          it = sb.pop_front();
          chk(it.tag, rsp_data, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rsp_valid after reset", {7'b0, rsp_valid}, 8'h00);
    chk("R1 req_ready after reset", {7'b0, req_ready}, 8'h01);
    rst_n = 1;
    rd(8'd4, "R1 R3 index4 at reset");
    rd(8'd5, "R1 index5 at reset");

    // R5 polarity sweep
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); apin = k[0]; ainv = k[1];
      rd(8'd4, "R5 alert polarity");
    end
    apin = 1; ainv = 0;

    // R2 held events
    pulse_intr();  rd(8'd4, "R2 intrusion held");
    pulse_therm(); rd(8'd4, "R2 thermal held");
    rd(8'd4, "R2 R11 repeat read unchanged");

    // R4 second expiry
    pulse_wdt(); rd(8'd4, "R4 single expiry bit3 clear");
    pulse_wdt(); rd(8'd4, "R4 second expiry bit3 set");

    // R3 R6 first fetch blank, later ignored
    fetch(8'hFF); rd(8'd4, "R3 boot fetched"); rd(8'd5, "R6 blank flash set");
    fetch(8'h00); rd(8'd5, "R6 later fetch ignored");

    // R7 live bits
    @(negedge clk); batlow_n = 0; cpufail = 1; ttrip = 1;
    rd(8'd5, "R7 live bits high");
    @(negedge clk); batlow_n = 1; cpufail = 0; ttrip = 0;
    rd(8'd5, "R7 live bits low");

    // R8 shutdown and power-ok-bad
    pulse_shut(); rd(8'd5, "R8 shutdown held");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); slp_n = k[0]; pwrok = k[1];
      rd(8'd5, "R8 power ok bad decode");
    end
    slp_n = 0; pwrok = 1;

    // R9 index map
    rd(8'd6, "R9 msg a"); rd(8'd7, "R9 msg b"); rd(8'd8, "R9 wdog status");
    rd(8'd0, "R9 low idx zero"); rd(8'd3, "R9 low idx zero");
    rd(8'd9, "R9 high idx zero"); rd(8'd100, "R9 high idx zero"); rd(8'd255, "R9 high idx zero");

    // R10 back-pressure
    @(negedge clk); rsp_ready = 0;
    rd(8'd6, "R10 stalled response data");
    @(negedge clk); msga = 8'h11;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 ready low while stalled", {7'b0, req_ready}, 8'h00);
    chk("R10 valid held while stalled", {7'b0, rsp_valid}, 8'h01);
    chk("R10 data held while stalled", rsp_data, 8'h3C);
    fork rd(8'd7, "R10 queued read after stall"); join_none
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    wait fork;

    // R11 state intact after many reads
    rd(8'd4, "R11 index4 after reads");
    rd(8'd5, "R11 index5 after reads");

    // R1 second reset, R6 reverse ordering
    do_reset();
    rd(8'd4, "R1 captured cleared");
    rd(8'd5, "R1 captured cleared idx5");
    fetch(8'h12); fetch(8'hFF);
    rd(8'd5, "R6 non-blank first fetch kept");
    rd(8'd4, "R3 fetched after second reset");

    repeat (4) @(negedge clk);
    chk("R10 scoreboard drained", 8'(sb.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule